// File: doc/BRIEF.md
# Sub-Scan Laplacian Edge Enhancer

This block sharpens a raster image along the sub-scan (vertical) axis. Pixels arrive one per valid cycle, in raster order. The block keeps the two previous lines in two chained line-delay buffers. As a result, three vertically aligned samples of the same column are available at once: the incoming line (below), the line before it (centre) and the line before that (above). The centre sample is then boosted by a scaled second difference against its two vertical neighbours. The result is clipped to the pixel range.

A `line_start` pulse marks the first pixel of every line and sends the column index back to zero, so the three taps always refer to the same column. A `frame_start` pulse marks the first pixel of a frame and restarts the count of lines seen. Until two complete lines are held, the incoming pixel is forwarded unchanged and `filt_valid` stays low. Each accepted pixel produces exactly one output pixel after a fixed pipeline delay.

Top module: `vsharp_filter`

## Requirements
- R1: While reset is asserted and after its release until the first result, `out_valid`, `filt_valid` and `out_pix` are all zero.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, two clock cycles later, with results in input order; no other cycle has `out_valid` high.
- R3: For pixels of line 0 and line 1 of a frame (the line carrying `frame_start` is line 0), `out_pix` equals the incoming pixel and `filt_valid` is 0.
- R4: From line 2 of a frame on, `filt_valid` is 1 and `out_pix` = N + K·(2N − A − B). B is the incoming pixel, N the pixel of the previous line in the same column, and A the pixel two lines back in the same column.
- R5: `gain` is a 4-bit unsigned number with 2 fractional bits (K = gain/4). The scaled term is K·(2N − A − B) computed exactly and rounded toward minus infinity. `gain` is sampled together with each pixel.
- R6: The enhanced result is clipped to 0 when negative and to 255 when above 255.
- R7: The column index restarts at 0 on every `line_start`, so lines shorter than `LINE_LEN` stay column-aligned. A line may hold up to `LINE_LEN` pixels. Within one frame, a line may not be longer than the line before it.
- R8: A `frame_start` returns the block to pass-through for the next two lines, whatever was stored before.
- R9: Cycles with `in_valid` low leave the column index, the stored lines and the line count unchanged and produce no output.
- R10: With `gain` = 0, the enhanced output equals the centre pixel N exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | 8 | Incoming pixel (line below the centre) |
| line_start | input | 1 | High with the first pixel of each line |
| frame_start | input | 1 | High with the first pixel of each frame |
| gain | input | 4 | Laplacian gain, unsigned, 2 fractional bits |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | 8 | Enhanced or forwarded pixel |
| filt_valid | output | 1 | High when `out_pix` carries an enhanced value |

## Verification
A column index that drifts after `line_start`, or a line buffer written on an idle cycle, is not visible until the third line of a frame. From that point, every enhanced pixel in the affected columns is wrong, as soon as the gain is non-zero. A line counter that restarts wrongly shows at once as `filt_valid` at the wrong level in the first pixel of a line. Arithmetic faults such as a wrong shift, a wrong rounding direction or missing clipping appear only in the pixel value two cycles after the input. For that reason the stimulus includes negative odd products, hard 0/255 edges and a gain that varies per pixel.

// File: rtl/vsharp_pkg.sv
package vsharp_pkg;
  localparam int PIX_W  = 8;
  localparam int K_W    = 4;
  localparam int K_FRAC = 2;
  localparam int LAP_W  = PIX_W + 3;
  localparam int PRD_W  = LAP_W + K_W + 1;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [K_W-1:0]   gain_t;

  typedef enum logic [1:0] {
    LN_FIRST  = 2'd0,
    LN_SECOND = 2'd1,
    LN_HIST   = 2'd2
  } line_ph_t;

  // second vertical difference 2N - A - B, signed
  function automatic logic signed [LAP_W-1:0] lap_of(pix_t n, pix_t a, pix_t b);
    logic signed [LAP_W-1:0] sn, sa, sb;
    sn = {{(LAP_W-PIX_W){1'b0}}, n};
    sa = {{(LAP_W-PIX_W){1'b0}}, a};
    sb = {{(LAP_W-PIX_W){1'b0}}, b};
    return (sn <<< 1) - sa - sb;
  endfunction

  // N + floor(gain * lap / 2^K_FRAC), clipped to the pixel range
  function automatic pix_t enhance(pix_t n, pix_t a, pix_t b, gain_t g);
    logic signed [LAP_W-1:0] lap;
    logic signed [PRD_W-1:0] lap_x, g_x, n_x, prod, sum;
    logic signed [PRD_W-1:0] pix_max;
    pix_max = PRD_W'((1 << PIX_W) - 1);
    lap   = lap_of(n, a, b);
    lap_x = {{(PRD_W-LAP_W){lap[LAP_W-1]}}, lap};
    g_x   = {{(PRD_W-K_W){1'b0}}, g};
    n_x   = {{(PRD_W-PIX_W){1'b0}}, n};
    prod  = lap_x * g_x;
    sum   = (prod >>> K_FRAC) + n_x;
    if (sum[PRD_W-1])        return '0;
    else if (sum > pix_max)  return '1;
    else                     return sum[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/vsharp_line_delay.sv
module vsharp_line_delay #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  logic [W-1:0] mem [0:DEPTH-1];

  // read returns the value from one line ago, before this cycle's write
  assign dout = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
  end
endmodule

// File: rtl/vsharp_tap_ctrl.sv
module vsharp_tap_ctrl
  import vsharp_pkg::*;
#(
  parameter int LINE_LEN = 256,
  localparam int AW      = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          line_start,
  input  logic          frame_start,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] col_q,
  output logic          hist_ok
);
  localparam logic [AW-1:0] LAST_COL = AW'(LINE_LEN - 1);

  line_ph_t ph_q, ph_cur;
  logic     new_line;

  assign new_line = line_start | frame_start;
  assign rd_addr  = new_line ? '0 : col_q;

  always_comb begin
    ph_cur = ph_q;
    if (frame_start) ph_cur = LN_FIRST;
    else if (line_start) begin
      case (ph_q)
        LN_FIRST:  ph_cur = LN_SECOND;
        default:   ph_cur = LN_HIST;
      endcase
    end
  end

  assign hist_ok = (ph_cur == LN_HIST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      ph_q  <= LN_FIRST;
    end else if (in_valid) begin
      col_q <= (rd_addr == LAST_COL) ? rd_addr : rd_addr + AW'(1);
      ph_q  <= ph_cur;
    end
  end
endmodule

// File: rtl/vsharp_kernel.sv
module vsharp_kernel
  import vsharp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  logic  hist_ok,
  input  pix_t  tap_above,
  input  pix_t  tap_centre,
  input  pix_t  tap_below,
  input  gain_t gain,
  output pix_t  s1_centre,
  output logic  out_valid,
  output pix_t  out_pix,
  output logic  filt_valid
);
  logic  s1_v, s1_f;
  pix_t  s1_a, s1_b;
  gain_t s1_g;

  // stage 1: register the aligned tap set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_f      <= 1'b0;
      s1_a      <= '0;
      s1_centre <= '0;
      s1_b      <= '0;
      s1_g      <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_f      <= hist_ok;
        s1_a      <= tap_above;
        s1_centre <= tap_centre;
        s1_b      <= tap_below;
        s1_g      <= gain;
      end
    end
  end

  // stage 2: arithmetic and clip
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      filt_valid <= 1'b0;
      out_pix    <= '0;
    end else begin
      out_valid  <= s1_v;
      filt_valid <= s1_v & s1_f;
      if (s1_v) out_pix <= s1_f ? enhance(s1_centre, s1_a, s1_b, s1_g) : s1_b;
    end
  end
endmodule

// File: rtl/vsharp_filter.sv
module vsharp_filter
  import vsharp_pkg::*;
#(
  parameter int LINE_LEN = 256,
  localparam int AW      = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             line_start,
  input  logic             frame_start,
  input  logic [K_W-1:0]   gain,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             filt_valid
);
  localparam int N_DLY = 2;

  logic [AW-1:0] rd_addr, col_q;
  logic          hist_ok;
  pix_t          taps [0:N_DLY];
  pix_t          tap_n_q;

  vsharp_tap_ctrl #(.LINE_LEN(LINE_LEN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .line_start(line_start), .frame_start(frame_start),
    .rd_addr(rd_addr), .col_q(col_q), .hist_ok(hist_ok)
  );

  assign taps[0] = in_pix;

  for (genvar i = 0; i < N_DLY; i++) begin : g_dly
    vsharp_line_delay #(.DEPTH(LINE_LEN), .W(PIX_W)) dly_i (
      .clk(clk), .we(in_valid), .addr(rd_addr),
      .din(taps[i]), .dout(taps[i+1])
    );
  end

  vsharp_kernel kern_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hist_ok(hist_ok),
    .tap_above(taps[2]), .tap_centre(taps[1]), .tap_below(taps[0]),
    .gain(gain), .s1_centre(tap_n_q),
    .out_valid(out_valid), .out_pix(out_pix), .filt_valid(filt_valid)
  );
endmodule

// File: rtl/vsharp_chk.sv
module vsharp_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [7:0]    in_pix,
  input logic          line_start,
  input logic          frame_start,
  input logic [3:0]    gain,
  input logic          out_valid,
  input logic [7:0]    out_pix,
  input logic          filt_valid,
  input logic [AW-1:0] col_q,
  input logic [7:0]    tap_n_q
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !filt_valid && out_pix == 8'd0));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid && !filt_valid) |-> (out_pix == $past(in_pix, 2)));

  p_filt_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    filt_valid |-> out_valid);

  p_col_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (line_start || frame_start)) |=> (col_q == AW'(1)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(col_q));

  p_zero_gain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid && filt_valid && $past(gain, 2) == 4'd0)
      |-> (out_pix == $past(tap_n_q)));
endmodule

bind vsharp_filter vsharp_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
  .line_start(line_start), .frame_start(frame_start), .gain(gain),
  .out_valid(out_valid), .out_pix(out_pix), .filt_valid(filt_valid),
  .col_q(col_q), .tap_n_q(tap_n_q)
);

// File: tb/vsharp_filter_tb_top.sv
module vsharp_filter_tb_top;
  localparam int LL = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic       line_start = 1'b0;
  logic       frame_start = 1'b0;
  logic [3:0] gain = '0;
  logic       out_valid, filt_valid;
  logic [7:0] out_pix;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  vsharp_filter #(.LINE_LEN(LL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .line_start(line_start), .frame_start(frame_start), .gain(gain),
    .out_valid(out_valid), .out_pix(out_pix), .filt_valid(filt_valid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  int    q_pix[$];
  bit    q_filt[$];
  int    q_cyc[$];
  string q_tag[$];

  // reference model state
  int m_above[LL];
  int m_centre[LL];
  int m_col = 0;
  int m_line = 0;

  function automatic int ref_enh(int n, int a, int b, int g);
    int lap, p, q, r;
    lap = 2 * n - a - b;
    p = g * lap;
    q = p / 4;
    if (p < 0 && (p % 4) != 0) q = q - 1;
    r = n + q;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic send(input int pix, input bit ls, input bit fs, input int g, input string tag);
    int e;
    bit f;
    string t;
    @(negedge clk);
    in_valid = 1'b1; in_pix = pix[7:0]; line_start = ls; frame_start = fs; gain = g[3:0];
    if (fs) begin m_line = 0; m_col = 0; end
    else if (ls) begin m_line = (m_line >= 2) ? 2 : m_line + 1; m_col = 0; end
    f = (m_line >= 2);
    e = f ? ref_enh(m_centre[m_col], m_above[m_col], pix, g) : pix;
    t = f ? tag : ((tag == "R8") ? "R8" : "R3");
    q_pix.push_back(e); q_filt.push_back(f); q_cyc.push_back(cyc + 2); q_tag.push_back(t);
    m_above[m_col] = m_centre[m_col];
    m_centre[m_col] = pix;
    if (m_col < LL - 1) m_col++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; line_start = 1'b0; frame_start = 1'b0;
      in_pix = 8'hA5; gain = 4'hF;
    end
  endtask

  // pat: 0 mixed, 1 hard 0/255 checkerboard, 2 smooth ramp
  // gmode: >=0 fixed gain, <0 gain = column mod 16
  task automatic frame(input int lines, input int len, input int gmode, input int pat,
                       input string tag, input bit gaps);
    for (int l = 0; l < lines; l++) begin
      for (int c = 0; c < len; c++) begin
        int p, g;
        case (pat)
          0: p = (c * 37 + l * 91 + 13) % 256;
          1: p = ((l + c) % 2) ? 255 : 0;
          default: p = (c * 8 + l * 40) % 256;
        endcase
        g = (gmode < 0) ? (c % 16) : gmode;
        send(p, c == 0, (c == 0) && (l == 0), g, tag);
        if (gaps && ((l * len + c) % 3 == 1)) idle(1 + (c % 2));
      end
    end
    idle(3);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        total++;
        if (q_pix.size() == 0) begin
          bad++;
          $display("FAIL R2 unexpected out_valid actual=1 expected=0 at cycle %0d", cyc);
        end else begin
          int e, c; bit f; string t;
          e = q_pix.pop_front(); f = q_filt.pop_front(); c = q_cyc.pop_front(); t = q_tag.pop_front();
          if (c != cyc) begin
            bad++;
            $display("FAIL R2 output cycle actual=%0d expected=%0d", cyc, c);
          end else if (out_pix != e[7:0] || filt_valid != f) begin
            bad++;
            $display("FAIL %s pix/filt actual=%0d/%0b expected=%0d/%0b", t, out_pix, filt_valid, e, f);
          end
        end
      end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
        total++; bad++;
        $display("FAIL R2 missing output actual=none expected=%0d at cycle %0d", q_pix[0], cyc);
        void'(q_pix.pop_front()); void'(q_filt.pop_front());
        void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check_quiet(input string what);
    total++;
    if (out_valid !== 1'b0 || filt_valid !== 1'b0 || out_pix !== 8'd0) begin
      bad++;
      $display("FAIL R1 %s actual=%0b/%0b/%0d expected=0/0/0", what, out_valid, filt_valid, out_pix);
    end
  endtask

  initial begin
    for (int i = 0; i < LL; i++) begin m_above[i] = 0; m_centre[i] = 0; end
    repeat (3) @(negedge clk);
    check_quiet("during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("after release");
    idle(2);
    check_quiet("idle after release");

    frame(5, LL, 4, 0, "R4", 1'b0);       // full lines, gain 1.0
    frame(4, LL, -1, 0, "R5", 1'b0);      // gain varies per pixel
    frame(4, 10, 15, 1, "R6", 1'b0);      // hard edges, max gain -> clipping
    frame(4, 10, 0, 0, "R10", 1'b0);      // zero gain
    frame(5, 7, 6, 2, "R7", 1'b0);        // short lines
    frame(5, 12, 9, 0, "R9", 1'b1);       // idle cycles in the stream
    frame(3, 12, 5, 2, "R4", 1'b0);
    frame(4, 12, 5, 0, "R8", 1'b0);       // restart right after a frame
    idle(4);

    total++;
    if (q_pix.size() != 0) begin
      bad++;
      $display("FAIL R2 pending outputs actual=%0d expected=0", q_pix.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule